// File: doc/BRIEF.md
# Local-to-Wishbone Master Bridge

The bridge turns single-clock write and read strobes from a simple local register port into classic single-transfer Wishbone master cycles. On the clock that a legal strobe is seen, the bridge registers the address, the write data and the direction. From the next clock it holds CYC and STB high with the registered address, direction and write data on the bus. It keeps them there until the slave answers with ACK or ERR.

The slave's answer produces a one-clock acknowledge or error pulse on the local side. A read also loads the sampled bus data into the local read-data register. A request that raises write and read together is dropped without starting a cycle. Strobes that arrive while a cycle is open are ignored. The local agent waits for the acknowledge or error pulse before it issues another request.

Top module: `loc2bus_master`

## Requirements
- R1: When the bridge is idle and exactly one of `loc_wr` and `loc_rd` is high at a rising edge, `bus_cyc` and `bus_stb` are both high from that edge on. They stay high until the slave responds.
- R2: When `loc_wr` and `loc_rd` are both high at an edge while the bridge is idle, no cycle starts and `bus_cyc` stays low.
- R3: Throughout an open cycle, `bus_adr` equals the `loc_adr` value present on the accepting edge, whatever `loc_adr` does afterwards.
- R4: In a write cycle `bus_we` is 1 and `bus_dat_o` equals the `loc_wdat` value present on the accepting edge. In a read cycle `bus_we` is 0.
- R5: An edge with `bus_cyc` high and `bus_ack` high (and `bus_err` low) ends the cycle: `bus_cyc` and `bus_stb` are low after that edge, and `loc_ack` is high for exactly that following clock. A read loads `bus_dat_i` from that edge into `loc_rdat`. `loc_rdat` keeps its value across write completions and error completions.
- R6: An edge with `bus_cyc` and `bus_err` high ends the cycle in the same way but pulses `loc_err` instead of `loc_ack`. When ACK and ERR arrive together, ERR wins.
- R7: Strobes seen while a cycle is open, including on the completing edge itself, start no new cycle and do not change `bus_adr`, `bus_we` or `bus_dat_o`.
- R8: `loc_ack` and `loc_err` are never high together. Each lasts one clock and is low in every clock without a completion.
- R9: Reset is synchronous and active high. After a reset edge, `bus_cyc`, `bus_stb`, `bus_we`, `loc_ack`, `loc_err` and `loc_rdat` are 0, even if a cycle was open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_wr | input | 1 | One-clock local write strobe |
| loc_rd | input | 1 | One-clock local read strobe |
| loc_adr | input | AW | Local address, valid with a strobe |
| loc_wdat | input | DW | Local write data, valid with the write strobe |
| loc_rdat | output | DW | Data from the last completed read |
| loc_ack | output | 1 | One-clock successful-completion pulse |
| loc_err | output | 1 | One-clock error-completion pulse |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_stb | output | 1 | Bus strobe |
| bus_we | output | 1 | Bus write enable |
| bus_adr | output | AW | Bus address |
| bus_dat_o | output | DW | Bus write data |
| bus_dat_i | input | DW | Bus read data from the slave |
| bus_ack | input | 1 | Slave acknowledge |
| bus_err | input | 1 | Slave error |

## Verification
Each bus output is due one clock after the accepting edge. Each local completion output is due one clock after the edge that samples ACK or ERR, and the completion pulse must be gone one clock after that. The bench changes inputs on falling edges and reads outputs on the next falling edge, so every check lands half a clock after the edge that produced the value. Each scenario task counts clocks from its own strobe: it checks the bus lines in every waiting clock, the completion in the clock right after the response, and the return to quiet in the clock after that.

// File: rtl/loc2bus_pkg.sv
`timescale 1ns/1ps
package loc2bus_pkg;

    // Phase of the single-transfer sequencer.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_BUS  = 1'b1
    } phase_e;

    // How the open cycle is being closed in the current clock.
    typedef enum logic [1:0] {
        FIN_NONE  = 2'd0,
        FIN_OK    = 2'd1,
        FIN_FAULT = 2'd2
    } fin_e;

    // A request is legal when exactly one direction is asked for.
    function automatic logic single_strobe(input logic wr, input logic rd);
        return wr ^ rd;
    endfunction

    // Error takes priority over acknowledge.
    function automatic fin_e classify(input logic live, input logic ack, input logic err);
        fin_e f;
        if (!live)     f = FIN_NONE;
        else if (err)  f = FIN_FAULT;
        else if (ack)  f = FIN_OK;
        else           f = FIN_NONE;
        return f;
    endfunction

endpackage

// File: rtl/loc2bus_capture.sv
`timescale 1ns/1ps
module loc2bus_capture
    import loc2bus_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          idle,
    input  logic          wr,
    input  logic          rd,
    input  logic [AW-1:0] adr,
    input  logic [DW-1:0] wdat,
    output logic          launch,
    output logic          cap_we,
    output logic [AW-1:0] cap_adr,
    output logic [DW-1:0] cap_dat
);

    // Accept only from idle and only a single-direction request.
    always_comb begin
        launch = idle && single_strobe(wr, rd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_we  <= 1'b0;
            cap_adr <= '0;
            cap_dat <= '0;
        end else if (launch) begin
            cap_we  <= wr;
            cap_adr <= adr;
            cap_dat <= wr ? wdat : '0;
        end
    end

endmodule

// File: rtl/loc2bus_seq.sv
`timescale 1ns/1ps
module loc2bus_seq
    import loc2bus_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic ack_i,
    input  logic err_i,
    output logic cyc,
    output logic stb,
    output logic idle,
    output fin_e fin
);

    phase_e phase_q, phase_d;

    always_comb begin
        fin     = classify(phase_q == PH_BUS, ack_i, err_i);
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: if (launch)          phase_d = PH_BUS;
            PH_BUS:  if (fin != FIN_NONE) phase_d = PH_IDLE;
            default:                      phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cyc     <= 1'b0;
            stb     <= 1'b0;
        end else begin
            phase_q <= phase_d;
            cyc     <= (phase_d == PH_BUS);
            stb     <= (phase_d == PH_BUS);
        end
    end

    always_comb begin
        idle = (phase_q == PH_IDLE);
    end

    // R1: STB never appears without CYC.
    p_stb_in_cyc_r1: assert property (@(posedge clk) disable iff (rst)
        stb |-> cyc);

endmodule

// File: rtl/loc2bus_reply.sv
`timescale 1ns/1ps
module loc2bus_reply
    import loc2bus_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  fin_e          fin,
    input  logic          cap_we,
    input  logic [DW-1:0] dat_i,
    output logic          l_ack,
    output logic          l_err,
    output logic [DW-1:0] l_rdat
);

    always_ff @(posedge clk) begin
        if (rst) begin
            l_ack  <= 1'b0;
            l_err  <= 1'b0;
            l_rdat <= '0;
        end else begin
            l_ack <= (fin == FIN_OK);
            l_err <= (fin == FIN_FAULT);
            if (fin == FIN_OK && !cap_we) begin
                l_rdat <= dat_i;
            end
        end
    end

    // R8: completion pulses are exclusive and one clock wide.
    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(l_ack && l_err));
    p_one_clk_r8: assert property (@(posedge clk) disable iff (rst)
        (l_ack || l_err) |=> !(l_ack || l_err));

endmodule

// File: rtl/loc2bus_master.sv
`timescale 1ns/1ps
module loc2bus_master
    import loc2bus_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          loc_wr,
    input  logic          loc_rd,
    input  logic [AW-1:0] loc_adr,
    input  logic [DW-1:0] loc_wdat,
    output logic [DW-1:0] loc_rdat,
    output logic          loc_ack,
    output logic          loc_err,
    output logic          bus_cyc,
    output logic          bus_stb,
    output logic          bus_we,
    output logic [AW-1:0] bus_adr,
    output logic [DW-1:0] bus_dat_o,
    input  logic [DW-1:0] bus_dat_i,
    input  logic          bus_ack,
    input  logic          bus_err
);

    logic idle;
    logic launch;
    logic cap_we;
    fin_e fin;

    loc2bus_capture #(.AW(AW), .DW(DW)) u_capture (
        .clk     (clk),
        .rst     (rst),
        .idle    (idle),
        .wr      (loc_wr),
        .rd      (loc_rd),
        .adr     (loc_adr),
        .wdat    (loc_wdat),
        .launch  (launch),
        .cap_we  (cap_we),
        .cap_adr (bus_adr),
        .cap_dat (bus_dat_o)
    );

    loc2bus_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .ack_i  (bus_ack),
        .err_i  (bus_err),
        .cyc    (bus_cyc),
        .stb    (bus_stb),
        .idle   (idle),
        .fin    (fin)
    );

    loc2bus_reply #(.DW(DW)) u_reply (
        .clk    (clk),
        .rst    (rst),
        .fin    (fin),
        .cap_we (cap_we),
        .dat_i  (bus_dat_i),
        .l_ack  (loc_ack),
        .l_err  (loc_err),
        .l_rdat (loc_rdat)
    );

    // Direction is shown on the bus only while a cycle is open.
    always_comb begin
        bus_we = bus_cyc && cap_we;
    end

    // R1: a single strobe from idle opens a cycle on the next clock.
    p_launch_r1: assert property (@(posedge clk) disable iff (rst)
        (!bus_cyc && (loc_wr ^ loc_rd)) |=> (bus_cyc && bus_stb));
    // R2: a double strobe from idle opens nothing.
    p_double_drop_r2: assert property (@(posedge clk) disable iff (rst)
        (!bus_cyc && loc_wr && loc_rd) |=> !bus_cyc);
    // R3: the address holds while the cycle stays open.
    p_adr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && !bus_ack && !bus_err) |=> $stable(bus_adr));
    // R4: a write carries the strobe-time address and data.
    p_write_fields_r4: assert property (@(posedge clk) disable iff (rst)
        (!bus_cyc && loc_wr && !loc_rd) |=>
            (bus_we && bus_dat_o == $past(loc_wdat) && bus_adr == $past(loc_adr)));
    // R4: a read drives WE low.
    p_read_we_r4: assert property (@(posedge clk) disable iff (rst)
        (!bus_cyc && loc_rd && !loc_wr) |=> !bus_we);
    // R5: acknowledge closes the cycle and pulses the local ack.
    p_ack_close_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && bus_ack && !bus_err) |=> (!bus_cyc && !bus_stb && loc_ack && !loc_err));
    // R6: error closes the cycle and pulses the local error.
    p_err_close_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && bus_err) |=> (!bus_cyc && loc_err && !loc_ack));
    // R7: a strobe during an open cycle does not reopen at the completing edge.
    p_busy_ignore_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && (bus_ack || bus_err)) |=> !bus_cyc);
    // R8: no completion pulse without a cycle having been open.
    p_no_stray_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_cyc) |-> !(loc_ack || loc_err));
    // R9: reset clears every control and result output.
    p_reset_r9: assert property (@(posedge clk)
        rst |=> (!bus_cyc && !bus_stb && !bus_we && !loc_ack && !loc_err && loc_rdat == '0));

endmodule

// File: tb/tb_loc2bus_master.sv
`timescale 1ns/1ps
module tb_loc2bus_master;

    localparam int AW = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          loc_wr = 1'b0;
    logic          loc_rd = 1'b0;
    logic [AW-1:0] loc_adr = '0;
    logic [DW-1:0] loc_wdat = '0;
    logic [DW-1:0] loc_rdat;
    logic          loc_ack;
    logic          loc_err;
    logic          bus_cyc;
    logic          bus_stb;
    logic          bus_we;
    logic [AW-1:0] bus_adr;
    logic [DW-1:0] bus_dat_o;
    logic [DW-1:0] bus_dat_i = '0;
    logic          bus_ack = 1'b0;
    logic          bus_err = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] last_rd = '0;

    always #4 clk = ~clk;

    loc2bus_master #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst(rst),
        .loc_wr(loc_wr), .loc_rd(loc_rd), .loc_adr(loc_adr), .loc_wdat(loc_wdat),
        .loc_rdat(loc_rdat), .loc_ack(loc_ack), .loc_err(loc_err),
        .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_adr(bus_adr), .bus_dat_o(bus_dat_o), .bus_dat_i(bus_dat_i),
        .bus_ack(bus_ack), .bus_err(bus_err)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // resp: 0 = ACK, 1 = ERR, 2 = ACK and ERR together.
    task automatic txn(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input int lat, input int resp, input logic [DW-1:0] sdat,
                       input logic intrude);
        @(negedge clk);
        loc_wr = w; loc_rd = !w; loc_adr = a; loc_wdat = d;
        @(negedge clk);
        loc_wr = 1'b0; loc_rd = 1'b0; loc_adr = '0; loc_wdat = '0;
        chk(bus_cyc && bus_stb, "R1 cyc/stb after accept", {30'd0, bus_cyc, bus_stb}, 32'd3);
        chk(bus_adr == a, "R3 address on bus", 32'(bus_adr), 32'(a));
        chk(bus_we == w, "R4 direction", 32'(bus_we), 32'(w));
        if (w) chk(bus_dat_o == d, "R4 write data", 32'(bus_dat_o), 32'(d));
        for (int i = 0; i < lat; i++) begin
            if (intrude && i == 0) begin
                loc_wr = 1'b1; loc_adr = ~a; loc_wdat = ~d;
            end
            @(negedge clk);
            loc_wr = 1'b0; loc_adr = '0; loc_wdat = '0;
            chk(bus_cyc && bus_adr == a, "R7/R3 cycle and address held", 32'(bus_adr), 32'(a));
            chk(bus_we == w, "R7 direction held", 32'(bus_we), 32'(w));
            chk(!loc_ack && !loc_err, "R8 quiet while waiting", {30'd0, loc_ack, loc_err}, 32'd0);
        end
        bus_ack = (resp != 1);
        bus_err = (resp != 0);
        bus_dat_i = sdat;
        if (intrude) loc_rd = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0; bus_err = 1'b0; bus_dat_i = '0; loc_rd = 1'b0;
        if (resp == 0 && !w) last_rd = sdat;
        chk(!bus_cyc && !bus_stb, "R5 cycle closed", {30'd0, bus_cyc, bus_stb}, 32'd0);
        if (resp == 0)
            chk(loc_ack && !loc_err, "R5 local ack", {30'd0, loc_ack, loc_err}, 32'd2);
        else
            chk(loc_err && !loc_ack, "R6 local err", {30'd0, loc_ack, loc_err}, 32'd1);
        chk(loc_rdat == last_rd, "R5 read data", 32'(loc_rdat), 32'(last_rd));
        @(negedge clk);
        chk(!loc_ack && !loc_err, "R8 pulse one clock", {30'd0, loc_ack, loc_err}, 32'd0);
        chk(!bus_cyc, "R7 no relaunch", 32'(bus_cyc), 32'd0);
    endtask

    task automatic t_reset;
        chk(!bus_cyc && !bus_stb && !bus_we, "R9 bus idle after reset",
            {29'd0, bus_cyc, bus_stb, bus_we}, 32'd0);
        chk(!loc_ack && !loc_err && loc_rdat == '0, "R9 local zero after reset",
            32'(loc_rdat), 32'd0);
    endtask

    task automatic t_double;
        @(negedge clk);
        loc_wr = 1'b1; loc_rd = 1'b1; loc_adr = 8'h5A; loc_wdat = 8'hA5;
        @(negedge clk);
        loc_wr = 1'b0; loc_rd = 1'b0;
        chk(!bus_cyc && !bus_stb, "R2 double strobe dropped", 32'(bus_cyc), 32'd0);
        @(negedge clk);
        chk(!bus_cyc && !loc_ack && !loc_err, "R2 still idle", {30'd0, loc_ack, loc_err}, 32'd0);
    endtask

    task automatic t_reset_midcycle;
        @(negedge clk);
        loc_rd = 1'b1; loc_adr = 8'h33;
        @(negedge clk);
        loc_rd = 1'b0;
        chk(bus_cyc, "R1 cycle before reset", 32'(bus_cyc), 32'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        last_rd = '0;
        chk(!bus_cyc && !bus_stb && !bus_we, "R9 reset closes cycle", 32'(bus_cyc), 32'd0);
        chk(loc_rdat == '0 && !loc_ack && !loc_err, "R9 reset clears read data", 32'(loc_rdat), 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        txn(1'b1, 8'h12, 8'hC3, 0, 0, 8'h00, 1'b0);  // zero-wait write
        txn(1'b0, 8'hF0, 8'h00, 2, 0, 8'h9E, 1'b0);  // read with wait states
        txn(1'b1, 8'h01, 8'h44, 1, 0, 8'h77, 1'b0);  // write keeps read data
        txn(1'b0, 8'h80, 8'h00, 1, 1, 8'h55, 1'b0);  // read error keeps data
        txn(1'b0, 8'hFF, 8'h00, 0, 2, 8'h66, 1'b0);  // ERR beats ACK
        txn(1'b0, 8'h00, 8'h00, 3, 0, 8'h3C, 1'b1);  // strobes while busy
        t_double();
        txn(1'b1, 8'hAA, 8'h0F, 2, 0, 8'h00, 1'b1);  // busy strobes on a write
        t_reset_midcycle();
        txn(1'b0, 8'h21, 8'h00, 0, 0, 8'hE1, 1'b0);  // works after reset
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule